// File: doc/BRIEF.md
# Root Port Error Interrupt Generator

This block holds the interrupt side of error reporting in a root port. Error messages arrive already decoded, each tagged with one of three severities: correctable, non-fatal or fatal. Each message sets a received flag for its severity in a root status register. A root command register holds one enable per severity. An interrupt fires only when the interrupt condition rises. The condition is the OR, over the three severities, of flag AND enable. Setting further flags while the condition already holds fires nothing.

A fired interrupt goes out on one of three paths, chosen in a fixed order. The first choice is a one-cycle MSI-X notification, then a one-cycle MSI notification, and the last is a level legacy line. The MSI-X and MSI notifications carry the interrupt message number. That number reads back in the top bits of the status register. Software reads both registers through a simple register port. It clears flags by writing ones to the status register, and it enables severities by writing the command register.

Top module: `rp_err_irq`

## Requirements
- R1: A message with `msg_sev_i` code 0 (correctable), 1 (non-fatal) or 2 (fatal) sets status flag bit 0, 1 or 2 respectively, one cycle after the edge that accepts it. It never clears a flag. Code 3 sets nothing.
- R2: The command register sits at address 0 with enables in bits [2:0], using the same bit order as the flags, and reads back what was written. The status register sits at address 1. Writing a 1 to a flag bit there clears that flag.
- R3: A message whose severity enable is clear raises no interrupt.
- R4: A message that arrives while some flag is already set with its enable set raises no interrupt.
- R5: An interrupt fires exactly when the condition goes from 0 to 1. That includes an enable being set while its flag is already set.
- R6: Delivery order is fixed. If `msix_en_i` is high, `msix_req_o` pulses for one cycle. Otherwise, if `msi_en_i` is high, `msi_req_o` pulses for one cycle. Otherwise `intx_o` goes high. The pulse appears in the cycle after the triggering edge, with `vec_o` equal to the message number.
- R7: `intx_o` stays high until the condition falls to 0, and then it drops.
- R8: A message and a software clear of the same flag in the same cycle leave that flag set.
- R9: Status bits [31:27] read the message number taken from `msg_num_i`. All other unused read bits are 0.
- R10: Reset clears every flag, every enable and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msg_valid_i | input | 1 | Error message arrives this cycle |
| msg_sev_i | input | 2 | Severity code of the message |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| msg_num_i | input | 5 | Interrupt message number |
| msix_en_i | input | 1 | MSI-X delivery enabled |
| msi_en_i | input | 1 | MSI delivery enabled |
| msix_req_o | output | 1 | One-cycle MSI-X notification |
| msi_req_o | output | 1 | One-cycle MSI notification |
| vec_o | output | 5 | Vector for the notification |
| intx_o | output | 1 | Legacy level interrupt |

## Verification
The bench first sends a second message while the condition is already true. A design that fires on every newly set bit would emit an extra notification there. Next, a fatal message arrives with only the correctable enable set, followed by a correctable message. A design that ORs all flags without masking them by the enables would miss the second interrupt. The bench then turns on an enable over a flag that is already set, which must fire exactly once, and issues a message and a clear of the same flag in one cycle, where a design that lets the clear win loses the flag. It also runs MSI-X and MSI together to confirm the priority, and checks that the legacy line holds while any enabled flag remains.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;
  localparam int unsigned NUM_SEV = 3;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  typedef logic [NUM_SEV-1:0] sev_mask_t;

  function automatic sev_mask_t sev_to_mask(input logic [1:0] sev);
    sev_mask_t m;
    for (int i = 0; i < NUM_SEV; i++) m[i] = (sev == i[1:0]);
    return m;
  endfunction
endpackage

// File: rtl/rp_err_regs.sv
module rp_err_regs
  import rp_err_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned VEC_W    = 5,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 0,
  parameter logic [ADDR_W-1:0] STS_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sev_mask_t         set_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [VEC_W-1:0]  msg_num_i,
  output sev_mask_t         en_nxt_o,
  output sev_mask_t         sts_nxt_o,
  output sev_mask_t         sts_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  sev_mask_t en_q, sts_q, clr;

  always_comb begin
    en_nxt_o = (wr_i && addr_i == CMD_ADDR) ? wdata_i[NUM_SEV-1:0] : en_q;
    clr      = (wr_i && addr_i == STS_ADDR) ? wdata_i[NUM_SEV-1:0] : '0;
    // set wins over a same-cycle clear
    sts_nxt_o = (sts_q & ~clr) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      en_q  <= en_nxt_o;
      sts_q <= sts_nxt_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CMD_ADDR) begin
      rdata_o[NUM_SEV-1:0] = en_q;
    end else if (addr_i == STS_ADDR) begin
      rdata_o[NUM_SEV-1:0]       = sts_q;
      rdata_o[DATA_W-1 -: VEC_W] = msg_num_i;
    end
  end

  assign sts_q_o = sts_q;
endmodule

// File: rtl/rp_err_trig.sv
module rp_err_trig
  import rp_err_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sev_mask_t sts_nxt_i,
  input  sev_mask_t en_nxt_i,
  output logic      cond_q_o,
  output logic      cond_nxt_o,
  output logic      fire_o
);
  assign cond_nxt_o = |(sts_nxt_i & en_nxt_i);
  assign fire_o     = cond_nxt_o & ~cond_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q_o <= 1'b0;
    else         cond_q_o <= cond_nxt_o;
  end
endmodule

// File: rtl/rp_err_deliver.sv
module rp_err_deliver #(
  parameter int unsigned VEC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             cond_nxt_i,
  input  logic             msix_en_i,
  input  logic             msi_en_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             msix_req_o,
  output logic             msi_req_o,
  output logic             intx_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msix_req_o <= 1'b0;
      msi_req_o  <= 1'b0;
      intx_o     <= 1'b0;
      vec_o      <= '0;
    end else begin
      msix_req_o <= fire_i & msix_en_i;
      msi_req_o  <= fire_i & ~msix_en_i & msi_en_i;
      if (fire_i) vec_o <= vec_i;
      if (!cond_nxt_i)                           intx_o <= 1'b0;
      else if (fire_i && !msix_en_i && !msi_en_i) intx_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rp_err_irq.sv
module rp_err_irq
  import rp_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned VEC_W  = 5,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 0,
  parameter logic [ADDR_W-1:0] STS_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [1:0]        msg_sev_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [VEC_W-1:0]  msg_num_i,
  input  logic              msix_en_i,
  input  logic              msi_en_i,
  output logic              msix_req_o,
  output logic              msi_req_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              intx_o
);
  sev_mask_t set_mask, en_nxt, sts_nxt, sts_q;
  logic      cond_q, cond_nxt, fire;

  assign set_mask = msg_valid_i ? sev_to_mask(msg_sev_i) : '0;

  rp_err_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
    .CMD_ADDR(CMD_ADDR), .STS_ADDR(STS_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .set_i(set_mask), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .msg_num_i,
    .en_nxt_o(en_nxt), .sts_nxt_o(sts_nxt), .sts_q_o(sts_q),
    .rdata_o(reg_rdata_o)
  );

  rp_err_trig u_trig (
    .clk_i, .rst_ni,
    .sts_nxt_i(sts_nxt), .en_nxt_i(en_nxt),
    .cond_q_o(cond_q), .cond_nxt_o(cond_nxt), .fire_o(fire)
  );

  rp_err_deliver #(.VEC_W(VEC_W)) u_deliver (
    .clk_i, .rst_ni,
    .fire_i(fire), .cond_nxt_i(cond_nxt),
    .msix_en_i, .msi_en_i, .vec_i(msg_num_i),
    .msix_req_o, .msi_req_o, .intx_o, .vec_o
  );
endmodule

// File: rtl/rp_err_irq_chk.sv
module rp_err_irq_chk
  import rp_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STS_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              msg_valid_i,
  input logic [1:0]        msg_sev_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              msix_req_o,
  input logic              msi_req_o,
  input logic              intx_o,
  input logic              cond_q,
  input sev_mask_t         sts_q
);
  // R6
  one_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({msix_req_o, msi_req_o, intx_o & (msix_req_o | msi_req_o)}));

  // R6
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msix_req_o || msi_req_o) |=> !(msix_req_o || msi_req_o));

  // R5
  rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msix_req_o || msi_req_o) |-> $past(!cond_q));

  // R7
  intx_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intx_o |-> cond_q);

  // R8
  msg_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_sev_i != 2'd3) |=> ((sts_q & sev_to_mask($past(msg_sev_i))) != '0));

  // R2
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == STS_ADDR && !msg_valid_i)
      |=> ((sts_q & $past(reg_wdata_i[NUM_SEV-1:0])) == '0));
endmodule

bind rp_err_irq rp_err_irq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR)
) i_chk (
  .clk_i, .rst_ni, .msg_valid_i, .msg_sev_i, .reg_wr_i, .reg_addr_i,
  .reg_wdata_i, .msix_req_o, .msi_req_o, .intx_o,
  .cond_q(cond_q), .sts_q(sts_q)
);

// File: tb/test_rp_err_irq.sv
`timescale 1ns/1ps
module test_rp_err_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  msg_num = 5'd9;
  logic        msix_en = 1'b0, msi_en = 1'b0;
  logic        msix_req, msi_req, intx;
  logic [4:0]  vec;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rp_err_irq i_rp_err_irq (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_sev_i(msg_sev),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .msg_num_i(msg_num), .msix_en_i(msix_en),
    .msi_en_i(msi_en), .msix_req_o(msix_req), .msi_req_o(msi_req),
    .vec_o(vec), .intx_o(intx)
  );

  // fields: mv sev wr adr wd xen men | ex em ei sts
  function automatic logic [15:0] v(input bit mv, input logic [1:0] sv, input bit wr,
                                    input bit ad, input logic [2:0] wd, input bit xe,
                                    input bit me, input bit ex, input bit em,
                                    input bit ei, input logic [2:0] es);
    return {mv, sv, wr, ad, wd, xe, me, ex, em, ei, es};
  endfunction

  localparam int NV = 19;
  localparam logic [15:0] TBL [NV] = '{
    v(0,0,1,0,3'b111,0,0, 0,0,0,3'b000), // R2 enable all
    v(1,0,0,0,3'b000,1,0, 1,0,0,3'b001), // R5 cor -> msix
    v(1,1,0,0,3'b000,1,0, 0,0,0,3'b011), // R4 already true
    v(0,0,1,1,3'b011,0,0, 0,0,0,3'b000), // R2 w1c
    v(1,2,0,0,3'b000,0,1, 0,1,0,3'b100), // R6 msi
    v(0,0,1,1,3'b100,0,0, 0,0,0,3'b000),
    v(1,0,0,0,3'b000,0,0, 0,0,1,3'b001), // R6 legacy
    v(1,2,0,0,3'b000,0,0, 0,0,1,3'b101), // R4 legacy held
    v(0,0,1,1,3'b001,0,0, 0,0,1,3'b100), // R7 still true
    v(0,0,1,1,3'b100,0,0, 0,0,0,3'b000), // R7 drops
    v(0,0,1,0,3'b001,0,0, 0,0,0,3'b000), // cor only
    v(1,2,0,0,3'b000,1,0, 0,0,0,3'b100), // R3 disabled sev
    v(1,0,0,0,3'b000,1,0, 1,0,0,3'b101), // R5 masked flag ignored
    v(0,0,1,1,3'b101,0,0, 0,0,0,3'b000),
    v(1,1,0,0,3'b000,1,1, 0,0,0,3'b010), // R3
    v(0,0,1,0,3'b010,1,1, 1,0,0,3'b010), // R5 enable rise, R6 priority
    v(1,1,1,1,3'b010,0,1, 0,0,0,3'b010), // R8 set beats clear
    v(0,0,1,1,3'b010,0,0, 0,0,0,3'b000),
    v(1,3,0,0,3'b000,1,0, 0,0,0,3'b000)  // R1 code 3 ignored
  };
  string tags [NV] = '{"R2","R5","R4","R2","R6","R2","R6","R4","R7","R7",
                       "R2","R3","R5","R2","R3","R5","R8","R2","R1"};

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R10 reset state
    chk("R10", "msix", {31'd0, msix_req}, 0);
    chk("R10", "msi",  {31'd0, msi_req}, 0);
    chk("R10", "intx", {31'd0, intx}, 0);
    read(2'd0, d); chk("R10", "cmd", d, 32'h0);
    // R9 message number in status top bits
    read(2'd1, d); chk("R9", "status", d, 32'h4800_0000);
    #1;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] t;
      t = TBL[i];
      msg_valid = t[15]; msg_sev = t[14:13]; reg_wr = t[12];
      reg_addr = {1'b0, t[11]}; reg_wdata = {29'd0, t[10:8]};
      msix_en = t[7]; msi_en = t[6];
      @(posedge clk); #1;
      chk(tags[i], "msix", {31'd0, msix_req}, {31'd0, t[5]});
      chk(tags[i], "msi",  {31'd0, msi_req},  {31'd0, t[4]});
      chk(tags[i], "intx", {31'd0, intx},     {31'd0, t[3]});
      if (t[5] | t[4]) chk("R6", "vector", {27'd0, vec}, 32'd9);
      msg_valid = 1'b0; reg_wr = 1'b0;
      read(2'd1, d);
      chk("R1", "flags", {29'd0, d[2:0]}, {29'd0, t[2:0]});
      #0.5;
    end

    read(2'd0, d); chk("R2", "cmd readback", d, 32'h2);

    // R10 reset while legacy line high
    msix_en = 1'b0; msi_en = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h7; msg_valid = 1'b1; msg_sev = 2'd0;
    @(posedge clk); #1;
    reg_wr = 1'b0; msg_valid = 1'b0;
    chk("R6", "intx raised", {31'd0, intx}, 1);
    rst_n = 1'b0; #1;
    chk("R10", "intx after reset", {31'd0, intx}, 0);
    read(2'd1, d); chk("R10", "flags after reset", {29'd0, d[2:0]}, 0);
    read(2'd0, d); chk("R10", "cmd after reset", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule